// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block takes reset requests from several places and turns them into four separate reset outputs. One output resets the host processor. One soft-resets the companion peripheral controller, so its configuration and the memory contents that depend on it are kept. One hard-resets that controller completely, including its configuration and clock logic. The fourth is a timed bus-reset line. The requests come from two debounced front-panel buttons (soft reset and abort), soft and hard requests from a remote debug host, a power-up indication, a watchdog timeout, and a strobe that fires when the processor runs its reset instruction.

A soft reset comes from the soft-reset button pressed alone, or from a host soft request. A hard reset comes from the soft-reset button pressed together with abort, from a host hard request, or from a watchdog timeout. The button path waits through a short qualification window before it commits to a soft reset, so an abort press that comes a little late still turns the event into a hard reset. Each reset is held for a fixed time after its last source goes away. A reset-instruction strobe produces a bus-reset pulse of a fixed length and leaves the processor running. Power-up forces the resets on asynchronously.

The classifier state machine has these states:
- POWERUP is the reset value. It moves to HARD_HOLD on the first clock.
- IDLE moves to HARD_ACT on any hard request, to SOFT_ACT on a host soft request, and to QUALIFY on the soft button.
- QUALIFY moves to HARD_ACT on a hard request, to SOFT_ACT on a host soft request or when the window ends, and back to IDLE if the button is released.
- SOFT_ACT moves to HARD_ACT on a hard request, and to SOFT_HOLD when no soft source is left.
- SOFT_HOLD moves to HARD_ACT on a hard request, back to SOFT_ACT if a soft source returns, and to IDLE when the hold time ends.
- HARD_ACT moves to HARD_HOLD when no hard source is left.
- HARD_HOLD moves back to HARD_ACT on a hard request, and to IDLE when the hold time ends.

Top module: `reset_arbiter`

## Requirements
- R1: While `por_n` is low, `cpu_rst_o`, `per_hard_rst_o` and `bus_rst_o` are 1 and `per_soft_rst_o` is 0, with no clock needed. After release, `bus_rst_o` is 0 within 2 cycles. `cpu_rst_o` and `per_hard_rst_o` return to 0 between 16 and 20 cycles after release.
- R2: A host soft request asserts `cpu_rst_o` and `per_soft_rst_o` within 4 cycles. `per_hard_rst_o` stays 0.
- R3: The soft button alone asserts nothing during the first 12 cycles of the press. `cpu_rst_o` and `per_soft_rst_o` are asserted by cycle 22 of the press.
- R4: If abort is added within 12 cycles of a soft-button press, `per_soft_rst_o` never asserts. `cpu_rst_o` and `per_hard_rst_o` assert within 4 cycles of the abort press.
- R5: A host hard request asserts `cpu_rst_o` and `per_hard_rst_o` within 4 cycles. `per_soft_rst_o` stays 0.
- R6: A watchdog timeout has the same effect as a hard request.
- R7: A hard request wins over any soft request. This holds when both arrive together and when a hard request arrives during an active soft reset: `per_soft_rst_o` drops and `per_hard_rst_o` asserts within 4 cycles.
- R8: After its last source is removed, an asserted processor or peripheral reset stays asserted for at least 16 cycles. It is released synchronously within 20 cycles.
- R9: Outside power-up, `per_soft_rst_o` and `per_hard_rst_o` are never 1 at the same time.
- R10: A rising edge on the reset-instruction strobe gives a `bus_rst_o` pulse exactly 512 cycles long.
- R11: A new strobe edge during a running pulse restarts the count. The total pulse length is then the spacing between the two strobes plus 512.
- R12: The reset-instruction strobe never asserts `cpu_rst_o`, `per_soft_rst_o` or `per_hard_rst_o`.
- R13: `bus_rst_o` rises within 4 cycles of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up indication, active low, asynchronous |
| btn_soft_i | input | 1 | Debounced soft-reset button |
| btn_abort_i | input | 1 | Debounced abort button |
| host_soft_req_i | input | 1 | Remote host soft-reset request |
| host_hard_req_i | input | 1 | Remote host hard-reset request |
| wdog_expire_i | input | 1 | Watchdog timeout |
| rst_insn_stb_i | input | 1 | Strobe raised when the reset instruction runs |
| cpu_rst_o | output | 1 | Processor reset |
| per_soft_rst_o | output | 1 | Peripheral soft reset, configuration kept |
| per_hard_rst_o | output | 1 | Peripheral hard reset, everything cleared |
| bus_rst_o | output | 1 | Timed bus-reset line |

## Verification
The bench builds the block with its default parameters:
- a two-stage synchronizer,
- a 16-cycle qualification window,
- a 16-cycle hold,
- a 512-cycle bus pulse.

With these values the full pulse length can be measured exactly, and restarts can be placed at random offsets inside a running pulse. The short windows let many random source choices and hold lengths fit in one run. Each choice is checked for the kind of reset it gives and for when that reset is released. A late abort press inside the qualification window is also reached.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_QUALIFY,
        ST_SOFT_ACT,
        ST_SOFT_HOLD,
        ST_HARD_ACT,
        ST_HARD_HOLD
    } rst_state_e;

    localparam int N_SRC     = 6;
    localparam int IX_BTN_S  = 0;
    localparam int IX_BTN_A  = 1;
    localparam int IX_HOST_S = 2;
    localparam int IX_HOST_H = 3;
    localparam int IX_WDOG   = 4;
    localparam int IX_INSN   = 5;
endpackage

// File: rtl/rst_sync_bit.sv
module rst_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_classifier.sv
module rst_classifier
    import rst_seq_pkg::*;
#(
    parameter int QUAL_CYCLES = 16,
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic btn_soft,
    input  logic btn_abort,
    input  logic host_soft,
    input  logic host_hard,
    input  logic wdog,
    output logic cpu_rst,
    output logic per_soft_rst,
    output logic per_hard_rst,
    output logic pwr_phase
);
    localparam int CNT_MAX = (QUAL_CYCLES > HOLD_CYCLES) ? QUAL_CYCLES : HOLD_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int QW      = $clog2(HOLD_CYCLES + 2);

    rst_state_e state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic hard_req, soft_any;

    assign hard_req = (btn_soft && btn_abort) || host_hard || wdog;
    assign soft_any = btn_soft || host_soft;

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= ST_POWERUP;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_POWERUP: state_n = ST_HARD_HOLD;
            ST_IDLE: begin
                if (hard_req)       state_n = ST_HARD_ACT;
                else if (host_soft) state_n = ST_SOFT_ACT;
                else if (btn_soft)  state_n = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (hard_req)       state_n = ST_HARD_ACT;
                else if (host_soft) state_n = ST_SOFT_ACT;
                else if (!btn_soft) state_n = ST_IDLE;
                else if (cnt == CW'(QUAL_CYCLES - 1)) state_n = ST_SOFT_ACT;
            end
            ST_SOFT_ACT: begin
                if (hard_req)       state_n = ST_HARD_ACT;
                else if (!soft_any) state_n = ST_SOFT_HOLD;
            end
            ST_SOFT_HOLD: begin
                if (hard_req)      state_n = ST_HARD_ACT;
                else if (soft_any) state_n = ST_SOFT_ACT;
                else if (cnt == CW'(HOLD_CYCLES - 1)) state_n = ST_IDLE;
            end
            ST_HARD_ACT: begin
                if (!hard_req) state_n = ST_HARD_HOLD;
            end
            ST_HARD_HOLD: begin
                if (hard_req) state_n = ST_HARD_ACT;
                else if (cnt == CW'(HOLD_CYCLES - 1)) state_n = ST_IDLE;
            end
            default: state_n = ST_POWERUP;
        endcase
    end

    // dwell counter: cleared on every transition, saturating otherwise
    always_comb begin
        if (state_n != state)          cnt_n = '0;
        else if (cnt != CW'(CNT_MAX))  cnt_n = cnt + 1'b1;
        else                           cnt_n = cnt;
    end

    // outputs
    always_comb begin
        cpu_rst      = 1'b0;
        per_soft_rst = 1'b0;
        per_hard_rst = 1'b0;
        pwr_phase    = 1'b0;
        unique case (state)
            ST_POWERUP: begin
                cpu_rst = 1'b1; per_hard_rst = 1'b1; pwr_phase = 1'b1;
            end
            ST_SOFT_ACT, ST_SOFT_HOLD: begin
                cpu_rst = 1'b1; per_soft_rst = 1'b1;
            end
            ST_HARD_ACT, ST_HARD_HOLD: begin
                cpu_rst = 1'b1; per_hard_rst = 1'b1;
            end
            default: ;
        endcase
    end

    // cycles since any source was last seen, for the hold check
    logic [QW-1:0] quiet;
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                        quiet <= '0;
        else if (hard_req || soft_any)      quiet <= '0;
        else if (quiet != QW'(HOLD_CYCLES + 1)) quiet <= quiet + 1'b1;
    end

    // R9
    soft_hard_excl_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !(per_soft_rst && per_hard_rst));

    // R7
    hard_wins_chk: assert property (@(posedge clk) disable iff (!arst_n)
        hard_req |=> (per_hard_rst && !per_soft_rst));

    // R8
    hold_time_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(cpu_rst) |-> (quiet >= QW'(HOLD_CYCLES)));

    // R2
    host_soft_direct_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_IDLE && host_soft && !hard_req) |=> (per_soft_rst && cpu_rst));
endmodule

// File: rtl/rst_bus_pulse.sv
module rst_bus_pulse #(
    parameter int PULSE_CYCLES = 512
) (
    input  logic clk,
    input  logic arst_n,
    input  logic stb,
    output logic pulse
);
    localparam int CW = $clog2(PULSE_CYCLES);
    localparam int RW = $clog2(PULSE_CYCLES + 1) + 1;

    logic          stb_q;
    logic          rise;
    logic [CW-1:0] cnt;

    assign rise = stb && !stb_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stb_q <= 1'b0;
            pulse <= 1'b0;
            cnt   <= '0;
        end else begin
            stb_q <= stb;
            if (rise) begin
                pulse <= 1'b1;
                cnt   <= '0;
            end else if (pulse) begin
                if (cnt == CW'(PULSE_CYCLES - 1)) pulse <= 1'b0;
                else                              cnt   <= cnt + 1'b1;
            end
        end
    end

    // length of the current high run, counted independently of cnt
    logic [RW-1:0] run_len;
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)    run_len <= '0;
        else if (rise)  run_len <= '0;
        else if (pulse) run_len <= run_len + 1'b1;
    end

    // R10
    pulse_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(pulse) |-> (run_len == RW'(PULSE_CYCLES)));

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
        rise |=> (pulse && run_len == '0));
endmodule

// File: rtl/reset_arbiter.sv
module reset_arbiter
    import rst_seq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_CYCLES  = 16,
    parameter int HOLD_CYCLES  = 16,
    parameter int PULSE_CYCLES = 512
) (
    input  logic clk,
    input  logic por_n,
    input  logic btn_soft_i,
    input  logic btn_abort_i,
    input  logic host_soft_req_i,
    input  logic host_hard_req_i,
    input  logic wdog_expire_i,
    input  logic rst_insn_stb_i,
    output logic cpu_rst_o,
    output logic per_soft_rst_o,
    output logic per_hard_rst_o,
    output logic bus_rst_o
);
    logic [N_SRC-1:0] raw, syn;
    logic pwr_phase, insn_pulse;

    always_comb begin
        raw            = '0;
        raw[IX_BTN_S]  = btn_soft_i;
        raw[IX_BTN_A]  = btn_abort_i;
        raw[IX_HOST_S] = host_soft_req_i;
        raw[IX_HOST_H] = host_hard_req_i;
        raw[IX_WDOG]   = wdog_expire_i;
        raw[IX_INSN]   = rst_insn_stb_i;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_sync
        rst_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .arst_n (por_n),
            .d      (raw[i]),
            .q      (syn[i])
        );
    end

    rst_classifier #(
        .QUAL_CYCLES (QUAL_CYCLES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_class (
        .clk          (clk),
        .arst_n       (por_n),
        .btn_soft     (syn[IX_BTN_S]),
        .btn_abort    (syn[IX_BTN_A]),
        .host_soft    (syn[IX_HOST_S]),
        .host_hard    (syn[IX_HOST_H]),
        .wdog         (syn[IX_WDOG]),
        .cpu_rst      (cpu_rst_o),
        .per_soft_rst (per_soft_rst_o),
        .per_hard_rst (per_hard_rst_o),
        .pwr_phase    (pwr_phase)
    );

    rst_bus_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk    (clk),
        .arst_n (por_n),
        .stb    (syn[IX_INSN]),
        .pulse  (insn_pulse)
    );

    assign bus_rst_o = insn_pulse || pwr_phase;

    // R12
    insn_no_cpu_chk: assert property (@(posedge clk) disable iff (!por_n)
        (insn_pulse && !pwr_phase && !syn[IX_BTN_S] && !syn[IX_HOST_S] && !syn[IX_HOST_H]
         && !syn[IX_WDOG] && !per_soft_rst_o && !per_hard_rst_o) |=> !per_soft_rst_o);
endmodule

// File: tb/tb_reset_arbiter.sv
module tb_reset_arbiter;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic btn_s = 1'b0, btn_a = 1'b0, h_soft = 1'b0, h_hard = 1'b0, wdog = 1'b0, stb = 1'b0;
    logic cpu_rst, per_soft, per_hard, bus_rst;

    int n_chk = 0, n_fail = 0;
    logic saw_cpu = 0, saw_soft = 0, saw_hard = 0, saw_both = 0;

    always #2 clk = ~clk;

    reset_arbiter dut (
        .clk(clk), .por_n(por_n),
        .btn_soft_i(btn_s), .btn_abort_i(btn_a),
        .host_soft_req_i(h_soft), .host_hard_req_i(h_hard),
        .wdog_expire_i(wdog), .rst_insn_stb_i(stb),
        .cpu_rst_o(cpu_rst), .per_soft_rst_o(per_soft),
        .per_hard_rst_o(per_hard), .bus_rst_o(bus_rst)
    );

    always @(negedge clk) begin
        if (cpu_rst)  saw_cpu  <= 1'b1;
        if (per_soft) saw_soft <= 1'b1;
        if (per_hard) saw_hard <= 1'b1;
        if (por_n && per_soft && per_hard) saw_both <= 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flags();
        saw_cpu = 0; saw_soft = 0; saw_hard = 0;
    endtask

    // count negedges until cpu_rst is low
    task automatic measure_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cpu_rst && n < 100);
    endtask

    // 0 btn soft alone, 1 chord, 2 host soft, 3 host hard, 4 watchdog
    function automatic bit expect_hard(input int src);
        return (src == 1 || src == 3 || src == 4);
    endfunction

    function automatic bit release_ok(input int n);
        return (n >= 16 && n <= 20);
    endfunction

    task automatic drive_src(input int src, input bit v);
        case (src)
            0: btn_s = v;
            1: begin btn_s = v; btn_a = v; end
            2: h_soft = v;
            3: h_hard = v;
            default: wdog = v;
        endcase
    endtask

    // strobe at index 0, optional restart at restart_at; returns latency and length
    task automatic pulse_run(input int restart_at, output int lat, output int len);
        lat = 0; len = 0;
        stb = 1'b1;
        for (int idx = 1; idx < 3000; idx++) begin
            @(negedge clk);
            stb = (idx == restart_at);
            if (bus_rst) begin
                len++;
                if (lat == 0) lat = idx;
            end else if (lat != 0 && idx > restart_at + 4) begin
                break;
            end
        end
        stb = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n, lat, len;
        void'($urandom(32'd2024));

        // R1 power-up forcing, no clock edge needed
        #1;
        chk(cpu_rst && per_hard && bus_rst && !per_soft, "R1 powerup outputs",
            {cpu_rst, per_soft, per_hard, bus_rst}, 4'b1011);
        cyc(3);
        por_n = 1'b1;
        cyc(2);
        chk(!bus_rst, "R1 bus_rst after release", bus_rst, 0);
        n = 2;
        while (cpu_rst && n < 100) begin @(negedge clk); n++; end
        chk(release_ok(n), "R1 powerup release time", n, 18);
        chk(!per_hard, "R1 per_hard released", per_hard, 0);
        cyc(4);

        // R2 host soft
        clear_flags();
        h_soft = 1'b1;
        cyc(4);
        chk(cpu_rst && per_soft, "R2 host soft asserts", {cpu_rst, per_soft}, 2'b11);
        cyc(6);
        h_soft = 1'b0;
        measure_release(n);
        chk(release_ok(n), "R8 hold after host soft", n, 18);
        chk(!saw_hard, "R2 no hard", saw_hard, 0);
        cyc(4);

        // R3 button alone qualifies
        clear_flags();
        btn_s = 1'b1;
        cyc(12);
        chk(!saw_cpu, "R3 nothing during window", saw_cpu, 0);
        cyc(10);
        chk(cpu_rst && per_soft && !per_hard, "R3 soft after window",
            {cpu_rst, per_soft, per_hard}, 3'b110);
        btn_s = 1'b0;
        measure_release(n);
        chk(release_ok(n), "R8 hold after button soft", n, 18);
        cyc(4);

        // R4 late abort turns into hard
        clear_flags();
        btn_s = 1'b1;
        cyc(8);
        btn_a = 1'b1;
        cyc(4);
        chk(cpu_rst && per_hard, "R4 chord gives hard", {cpu_rst, per_hard}, 2'b11);
        cyc(20);
        chk(!saw_soft, "R4 soft never asserted", saw_soft, 0);
        btn_s = 1'b0; btn_a = 1'b0;
        measure_release(n);
        chk(release_ok(n), "R8 hold after chord", n, 18);
        cyc(4);

        // R5 host hard
        clear_flags();
        h_hard = 1'b1;
        cyc(4);
        chk(cpu_rst && per_hard && !per_soft, "R5 host hard asserts",
            {cpu_rst, per_soft, per_hard}, 3'b101);
        h_hard = 1'b0;
        measure_release(n);
        chk(release_ok(n), "R8 hold after host hard", n, 18);
        chk(!saw_soft, "R5 no soft", saw_soft, 0);
        cyc(4);

        // R6 watchdog
        clear_flags();
        wdog = 1'b1;
        cyc(4);
        chk(cpu_rst && per_hard && !per_soft, "R6 watchdog hard",
            {cpu_rst, per_soft, per_hard}, 3'b101);
        wdog = 1'b0;
        measure_release(n);
        chk(release_ok(n), "R8 hold after watchdog", n, 18);
        cyc(4);

        // R7 simultaneous soft and hard
        clear_flags();
        h_soft = 1'b1; h_hard = 1'b1;
        cyc(4);
        chk(per_hard && !per_soft, "R7 simultaneous", {per_soft, per_hard}, 2'b01);
        h_soft = 1'b0; h_hard = 1'b0;
        measure_release(n);
        chk(!saw_soft, "R7 soft never during simultaneous", saw_soft, 0);
        cyc(4);

        // R7 hard arrives during soft
        h_soft = 1'b1;
        cyc(6);
        chk(per_soft, "R7 soft active first", per_soft, 1);
        h_hard = 1'b1;
        cyc(4);
        chk(per_hard && !per_soft, "R7 hard takes over", {per_soft, per_hard}, 2'b01);
        h_soft = 1'b0; h_hard = 1'b0;
        measure_release(n);
        chk(release_ok(n), "R8 hold after takeover", n, 18);
        cyc(4);

        // R10 R12 R13 single pulse
        clear_flags();
        pulse_run(-10, lat, len);
        chk(lat >= 1 && lat <= 4, "R13 pulse latency", lat, 3);
        chk(len == 512, "R10 pulse length", len, 512);
        chk(!saw_cpu && !saw_soft && !saw_hard, "R12 no reset from instruction",
            {saw_cpu, saw_soft, saw_hard}, 0);
        cyc(4);

        // R11 restarts at random offsets, plus directed late restart
        for (int k = 0; k < 5; k++) begin
            automatic int d = (k == 4) ? 511 : 20 + int'($urandom_range(480));
            clear_flags();
            pulse_run(d, lat, len);
            chk(len == d + 512, "R11 restart length", len, d + 512);
            chk(!saw_cpu, "R12 no cpu reset on restart", saw_cpu, 0);
            cyc(3);
        end

        // random source mix
        for (int k = 0; k < 24; k++) begin
            automatic int src = int'($urandom_range(4));
            automatic int hold = 24 + int'($urandom_range(36));
            clear_flags();
            drive_src(src, 1'b1);
            cyc(22);
            if (expect_hard(src))
                chk(per_hard && !per_soft, "R5 random hard kind", {per_soft, per_hard}, 2'b01);
            else
                chk(per_soft && !per_hard, "R2 random soft kind", {per_soft, per_hard}, 2'b10);
            cyc(hold - 22);
            drive_src(src, 1'b0);
            measure_release(n);
            chk(release_ok(n), "R8 random release", n, 18);
            cyc(2 + int'($urandom_range(5)));
        end

        chk(!saw_both, "R9 soft and hard exclusive", saw_both, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule